// File: doc/BRIEF.md
# Endpoint Transaction Status Bank

This block holds one status byte for each of sixteen endpoints. Index 0 is the control OUT endpoint, index 1 is control IN, and indices 2 to 15 are the data endpoints. The USB engine reports every finished transaction on an event port. Each report carries the endpoint index, a success flag, the data PID toggle and a 4-bit error code. The block folds the report into that endpoint's byte. It also keeps an unread marker, so it can tell when a result is overwritten before software has seen it.

A microprocessor reads a status byte in two steps. First it writes a command byte in the range A0h to AFh; the low nibble names the endpoint. Then it pulses a read strobe, and the byte appears one clock later with a valid flag.

The block also guards the buffer commands of the two control endpoints. A setup packet locks them. While the lock is held, validate-buffer and clear-buffer requests aimed at those endpoints are dropped and flagged. The acknowledge command F4h releases the lock.

Top module: `ep_status_bank`

## Requirements
- R1: A command byte whose upper nibble is Ah selects endpoint index = low nibble (0 control OUT, 1 control IN). The next `rd_strobe` puts that endpoint's byte on `rd_data` with `rd_valid` high for one cycle, one clock after the strobe. A strobe with no status command pending since the last completed read gives no `rd_valid`.
- R2: The status byte layout is: bit 7 overrun, bit 6 PID type, bit 5 always 0, bits 4:1 error code, bit 0 transaction OK. After reset every endpoint reads 00h, and `rd_valid`, `ctrl_locked`, `buf_validate`, `buf_clear` and `buf_reject` are 0.
- R3: Each event overwrites the error code and the OK bit of its endpoint with the reported values.
- R4: The PID bit takes `evt_pid` (0 = DATA0, 1 = DATA1) only on an event with `evt_ok` = 1. On a failed event it keeps its previous value.
- R5: An event for an endpoint whose previous status is still unread sets that endpoint's overrun bit.
- R6: A completed read marks the endpoint as read and clears its overrun bit. If an event for the same endpoint arrives in the same clock as the read strobe, the read returns the byte as it was before that event, and the overrun bit becomes 1 again.
- R7: `setup_seen` sets `ctrl_locked` from the next cycle. Command F4h clears it from the next cycle. If both arrive in the same cycle, the lock is set.
- R8: While `ctrl_locked` = 1, a validate command (FAh) or a clear command (F2h) whose `cmd_ep` is 0 or 1 produces no `buf_validate` or `buf_clear` pulse. Instead it produces a one-cycle `buf_reject` pulse one clock later.
- R9: Any other validate or clear command produces a one-cycle `buf_validate` or `buf_clear` pulse one clock later, with `buf_ep` equal to `cmd_ep`.
- R10: Command codes outside A0h to AFh, F4h, FAh and F2h have no effect: they arm no read and cause no buffer or reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Transaction report strobe |
| evt_ep | input | 4 | Endpoint index of the report |
| evt_ok | input | 1 | Transaction completed without error |
| evt_pid | input | 1 | Data PID toggle of the packet (0 = DATA0) |
| evt_err | input | 4 | Error code of the transaction |
| setup_seen | input | 1 | A setup packet has arrived |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| cmd_ep | input | 4 | Target endpoint of a buffer command |
| rd_strobe | input | 1 | Data read strobe for a status command |
| rd_data | output | 8 | Status byte returned by the read |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| ctrl_locked | output | 1 | Control-endpoint buffer commands are locked |
| buf_validate | output | 1 | Validate-buffer pulse toward the buffer manager |
| buf_clear | output | 1 | Clear-buffer pulse toward the buffer manager |
| buf_ep | output | 4 | Endpoint of the last buffer request |
| buf_reject | output | 1 | A buffer request was refused by the lock |

## Verification
The hardest case to reach is a transaction event that lands in the same clock as the read strobe for the same endpoint. In that cycle the returned byte must show the old contents, while the stored byte picks up both the new result and a fresh overrun bit. The bench arms the read with a status command, then drives the event and the strobe on one falling edge, and reads the endpoint twice more. Those two reads show the overrun bit first set and then cleared. A second corner is a setup packet and the acknowledge command in the same cycle; the bench drives both together and checks that the lock holds.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

    localparam int ERR_W = 4;

    // One endpoint's stored result
    typedef struct packed {
        logic             ovr;
        logic             pid;
        logic [ERR_W-1:0] err;
        logic             ok;
    } ep_stat_t;

    localparam logic [7:0] CMD_STAT_BASE    = 8'hA0;
    localparam logic [7:0] CMD_SETUP_ACK    = 8'hF4;
    localparam logic [7:0] CMD_BUF_VALIDATE = 8'hFA;
    localparam logic [7:0] CMD_BUF_CLEAR    = 8'hF2;

    // Status byte as the microprocessor sees it; bit 5 is always zero
    function automatic logic [7:0] stat_to_byte(ep_stat_t s);
        return {s.ovr, s.pid, 1'b0, s.err, s.ok};
    endfunction

endpackage

// File: rtl/ep_stat_file.sv
module ep_stat_file
    import ep_status_pkg::*;
#(
    parameter int N_EP = 16,
    parameter int EP_W = $clog2(N_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [EP_W-1:0]  evt_ep,
    input  logic             evt_ok,
    input  logic             evt_pid,
    input  logic [ERR_W-1:0] evt_err,
    input  logic             rd_fire,
    input  logic [EP_W-1:0]  rd_ep,
    output ep_stat_t         rd_stat
);

    typedef struct packed {
        ep_stat_t [N_EP-1:0] stat;
        logic     [N_EP-1:0] unread;
    } file_st_t;

    file_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Completing a read marks the endpoint as seen
        if (rd_fire) begin
            st_d.unread[rd_ep]   = 1'b0;
            st_d.stat[rd_ep].ovr = 1'b0;
        end
        // A new result overrides the read in the same cycle
        if (evt_valid) begin
            st_d.stat[evt_ep].err = evt_err;
            st_d.stat[evt_ep].ok  = evt_ok;
            if (evt_ok) begin
                st_d.stat[evt_ep].pid = evt_pid;
            end
            if (st_q.unread[evt_ep]) begin
                st_d.stat[evt_ep].ovr = 1'b1;
            end
            st_d.unread[evt_ep] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_stat = st_q.stat[rd_ep];

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && st_q.unread[evt_ep]) |=> st_q.stat[$past(evt_ep)].ovr);

    // R4
    pid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ok) |=>
            (st_q.stat[$past(evt_ep)].pid == $past(st_q.stat[evt_ep].pid)));

    // R3
    err_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (st_q.stat[$past(evt_ep)].err == $past(evt_err)));

endmodule

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
    import ep_status_pkg::*;
#(
    parameter int N_EP = 16,
    parameter int EP_W = $clog2(N_EP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic            rd_strobe,
    input  ep_stat_t        rd_stat,
    output logic [EP_W-1:0] sel_ep,
    output logic            rd_fire,
    output logic [7:0]      rd_data,
    output logic            rd_valid,
    output logic            setup_ack,
    output logic            val_req,
    output logic            clr_req
);

    typedef struct packed {
        logic [EP_W-1:0] sel;
        logic            armed;
        logic [7:0]      data;
        logic            valid;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    is_stat_cmd;

    assign is_stat_cmd = cmd_valid && (cmd_code[7:EP_W] == CMD_STAT_BASE[7:EP_W]);
    assign rd_fire     = rd_strobe && st_q.armed;
    assign setup_ack   = cmd_valid && (cmd_code == CMD_SETUP_ACK);
    assign val_req     = cmd_valid && (cmd_code == CMD_BUF_VALIDATE);
    assign clr_req     = cmd_valid && (cmd_code == CMD_BUF_CLEAR);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rd_fire) begin
            st_d.data  = stat_to_byte(rd_stat);
            st_d.valid = 1'b1;
            st_d.armed = 1'b0;
        end
        if (is_stat_cmd) begin
            st_d.sel   = cmd_code[EP_W-1:0];
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_ep   = st_q.sel;
    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;

    // R1
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && st_q.armed) |=> rd_valid);

    // R1
    no_stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !st_q.armed) |=> !rd_valid);

    // R2
    always_ff @(posedge clk) begin
        if (rst_n) begin
            reserved_zero_chk: assert (rd_data[5] == 1'b0);
        end
    end

endmodule

// File: rtl/ep_buf_gate.sv
module ep_buf_gate #(
    parameter int N_EP   = 16,
    parameter int N_CTRL = 2,
    parameter int EP_W   = $clog2(N_EP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            setup_seen,
    input  logic            setup_ack,
    input  logic            val_req,
    input  logic            clr_req,
    input  logic [EP_W-1:0] req_ep,
    output logic            locked,
    output logic            buf_validate,
    output logic            buf_clear,
    output logic            buf_reject,
    output logic [EP_W-1:0] buf_ep
);

    typedef struct packed {
        logic            lock;
        logic            val;
        logic            clr;
        logic            rej;
        logic [EP_W-1:0] ep;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     is_ctrl;
    logic     blocked;

    assign is_ctrl = (req_ep < EP_W'(N_CTRL));
    assign blocked = (val_req || clr_req) && is_ctrl && st_q.lock;

    always_comb begin
        st_d = st_q;
        if (setup_ack) begin
            st_d.lock = 1'b0;
        end
        if (setup_seen) begin
            st_d.lock = 1'b1;
        end
        st_d.val = val_req && !blocked;
        st_d.clr = clr_req && !blocked;
        st_d.rej = blocked;
        if (val_req || clr_req) begin
            st_d.ep = req_ep;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked       = st_q.lock;
    assign buf_validate = st_q.val;
    assign buf_clear    = st_q.clr;
    assign buf_reject   = st_q.rej;
    assign buf_ep       = st_q.ep;

    // R7
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_seen |=> locked);

    // R8
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && (val_req || clr_req) && (req_ep < EP_W'(N_CTRL)))
            |=> (buf_reject && !buf_validate && !buf_clear));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_validate, buf_clear, buf_reject}));

endmodule

// File: rtl/ep_status_bank.sv
module ep_status_bank
    import ep_status_pkg::*;
#(
    parameter int N_EP   = 16,
    parameter int N_CTRL = 2,
    parameter int EP_W   = $clog2(N_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [EP_W-1:0]  evt_ep,
    input  logic             evt_ok,
    input  logic             evt_pid,
    input  logic [ERR_W-1:0] evt_err,
    input  logic             setup_seen,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [EP_W-1:0]  cmd_ep,
    input  logic             rd_strobe,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             ctrl_locked,
    output logic             buf_validate,
    output logic             buf_clear,
    output logic [EP_W-1:0]  buf_ep,
    output logic             buf_reject
);

    ep_stat_t        sel_stat;
    logic [EP_W-1:0] sel_ep;
    logic            rd_fire;
    logic            setup_ack;
    logic            val_req;
    logic            clr_req;

    ep_stat_file #(.N_EP(N_EP), .EP_W(EP_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_ep    (evt_ep),
        .evt_ok    (evt_ok),
        .evt_pid   (evt_pid),
        .evt_err   (evt_err),
        .rd_fire   (rd_fire),
        .rd_ep     (sel_ep),
        .rd_stat   (sel_stat)
    );

    ep_cmd_decode #(.N_EP(N_EP), .EP_W(EP_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .rd_strobe (rd_strobe),
        .rd_stat   (sel_stat),
        .sel_ep    (sel_ep),
        .rd_fire   (rd_fire),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .setup_ack (setup_ack),
        .val_req   (val_req),
        .clr_req   (clr_req)
    );

    ep_buf_gate #(.N_EP(N_EP), .N_CTRL(N_CTRL), .EP_W(EP_W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_seen   (setup_seen),
        .setup_ack    (setup_ack),
        .val_req      (val_req),
        .clr_req      (clr_req),
        .req_ep       (cmd_ep),
        .locked       (ctrl_locked),
        .buf_validate (buf_validate),
        .buf_clear    (buf_clear),
        .buf_reject   (buf_reject),
        .buf_ep       (buf_ep)
    );

endmodule

// File: tb/tb_ep_status_bank.sv
`timescale 1ns/1ps
module tb_ep_status_bank;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_valid, evt_ok, evt_pid, setup_seen, cmd_valid, rd_strobe;
    logic [3:0] evt_ep, evt_err, cmd_ep;
    logic [7:0] cmd_code;
    logic [7:0] rd_data;
    logic       rd_valid, ctrl_locked, buf_validate, buf_clear, buf_reject;
    logic [3:0] buf_ep;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ep_status_bank dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ep(evt_ep),
        .evt_ok(evt_ok), .evt_pid(evt_pid), .evt_err(evt_err),
        .setup_seen(setup_seen), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_ep(cmd_ep), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_valid(rd_valid), .ctrl_locked(ctrl_locked),
        .buf_validate(buf_validate), .buf_clear(buf_clear),
        .buf_ep(buf_ep), .buf_reject(buf_reject)
    );

    typedef struct packed {
        logic [3:0] ep;
        logic       ok;
        logic       pid;
        logic [3:0] err;
        logic       rd;
        logic [7:0] exp;
    } vec_t;

    // event, optional status read, expected byte
    localparam vec_t VEC [8] = '{
        '{4'd2,  1'b1, 1'b1, 4'd0, 1'b1, 8'h41},  // R3 R4 ok DATA1
        '{4'd2,  1'b0, 1'b0, 4'd5, 1'b1, 8'h4A},  // R4 pid kept on failure
        '{4'd5,  1'b1, 1'b0, 4'd0, 1'b0, 8'h00},  // left unread
        '{4'd5,  1'b0, 1'b1, 4'd6, 1'b1, 8'h8C},  // R5 overrun
        '{4'd15, 1'b1, 1'b1, 4'd0, 1'b1, 8'h41},  // R1 last index
        '{4'd0,  1'b0, 1'b1, 4'd1, 1'b1, 8'h02},  // R1 control OUT
        '{4'd5,  1'b1, 1'b1, 4'd0, 1'b1, 8'h41},  // R6 overrun cleared by read
        '{4'd1,  1'b0, 1'b0, 4'd7, 1'b1, 8'h0E}   // R1 control IN
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_evt(input logic [3:0] ep, input logic ok, input logic pid,
                            input logic [3:0] err);
        evt_valid = 1'b1; evt_ep = ep; evt_ok = ok; evt_pid = pid; evt_err = err;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] code, input logic [3:0] ep);
        cmd_valid = 1'b1; cmd_code = code; cmd_ep = ep;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] d, output logic v);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic read_ep(input logic [3:0] ep, output logic [7:0] d, output logic v);
        send_cmd(8'hA0 | {4'h0, ep}, 4'd0);
        do_read(d, v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       v;
        rst_n = 1'b0;
        evt_valid = 0; evt_ep = 0; evt_ok = 0; evt_pid = 0; evt_err = 0;
        setup_seen = 0; cmd_valid = 0; cmd_code = 0; cmd_ep = 0; rd_strobe = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state of the outputs
        chk("R2 reset outputs", {3'b0, rd_valid, ctrl_locked, buf_validate, buf_clear, buf_reject}, 8'h00);
        read_ep(4'd9, d, v);
        chk("R2 untouched endpoint", d, 8'h00);
        chk("R1 rd_valid after read", {7'b0, v}, 8'h01);

        for (int i = 0; i < 8; i++) begin
            send_evt(VEC[i].ep, VEC[i].ok, VEC[i].pid, VEC[i].err);
            if (VEC[i].rd) begin
                read_ep(VEC[i].ep, d, v);
                chk($sformatf("R3 vector %0d", i), d, VEC[i].exp);
            end
        end

        // R6 event in the same clock as the read strobe
        send_evt(4'd3, 1'b1, 1'b0, 4'd0);
        send_cmd(8'hA3, 4'd0);
        rd_strobe = 1'b1;
        evt_valid = 1'b1; evt_ep = 4'd3; evt_ok = 1'b0; evt_pid = 1'b1; evt_err = 4'd4;
        @(negedge clk);
        rd_strobe = 1'b0; evt_valid = 1'b0;
        chk("R6 read returns pre-event byte", d == d ? rd_data : 8'hxx, 8'h01);
        read_ep(4'd3, d, v);
        chk("R6 overrun set again", d, 8'h88);
        read_ep(4'd3, d, v);
        chk("R6 overrun cleared by read", d, 8'h08);

        // R1 strobe without a pending status command
        do_read(d, v);
        chk("R1 stray strobe", {7'b0, v}, 8'h00);

        // R10 unknown command arms nothing and pulses nothing
        send_cmd(8'h55, 4'd0);
        chk("R10 no pulse", {5'b0, buf_validate, buf_clear, buf_reject}, 8'h00);
        do_read(d, v);
        chk("R10 no read armed", {7'b0, v}, 8'h00);

        // R9 unlocked control endpoint passes
        send_cmd(8'hF2, 4'd0);
        chk("R9 clear pulse", {buf_ep, 1'b0, buf_validate, buf_clear, buf_reject}, 8'h02);

        // R7 lock on setup
        setup_seen = 1'b1;
        @(negedge clk);
        setup_seen = 1'b0;
        chk("R7 locked", {7'b0, ctrl_locked}, 8'h01);

        // R8 control endpoint requests refused
        send_cmd(8'hFA, 4'd0);
        chk("R8 validate ep0 refused", {5'b0, buf_validate, buf_clear, buf_reject}, 8'h01);
        @(negedge clk);
        chk("R8 reject one cycle", {7'b0, buf_reject}, 8'h00);
        send_cmd(8'hF2, 4'd1);
        chk("R8 clear ep1 refused", {5'b0, buf_validate, buf_clear, buf_reject}, 8'h01);

        // R9 data endpoint passes under lock
        send_cmd(8'hFA, 4'd4);
        chk("R9 validate ep4", {buf_ep, 1'b0, buf_validate, buf_clear, buf_reject}, 8'h44);
        @(negedge clk);
        chk("R9 validate one cycle", {7'b0, buf_validate}, 8'h00);

        // R7 acknowledge releases
        send_cmd(8'hF4, 4'd0);
        chk("R7 unlocked by ack", {7'b0, ctrl_locked}, 8'h00);
        send_cmd(8'hFA, 4'd1);
        chk("R9 validate ep1 after ack", {buf_ep, 1'b0, buf_validate, buf_clear, buf_reject}, 8'h14);

        // R7 setup and ack together: lock wins
        setup_seen = 1'b1;
        send_cmd(8'hF4, 4'd0);
        setup_seen = 1'b0;
        chk("R7 setup beats ack", {7'b0, ctrl_locked}, 8'h01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule